// File: doc/BRIEF.md
# Ping-Pong Sample Buffer

This block takes a continuous stream of 8-bit samples and stores it in two equal memory banks that alternate. Samples arriving on the write side go to the current fill bank at consecutive addresses. When the last address of that bank is written, the next sample goes to address zero of the other bank with no missed cycle. At that moment the full bank is marked ready and an interrupt is raised toward the processor side.

The processor side reads the ready bank through its own address and data port, one cycle of latency, while the other bank keeps filling. It then pulses a release input, which drops the interrupt. If the writer completes a bank while the previous one has not been released, the older unread data is overwritten, the ready marker moves to the newer bank and a sticky overrun flag is raised. Only a reset clears that flag.

Top module: `pingpong_sample_buf`

## Requirements
- R1: After reset, ready_bank_o is 0, irq_o is 0, overrun_o is 0 and the first valid sample is stored at address 0 of bank 0.
- R2: Each cycle with smp_valid_i high stores smp_data_i at the next address of the current fill bank; cycles with smp_valid_i low store nothing and do not advance the address.
- R3: The sample that follows the one written to the last address (DEPTH-1) of a bank is stored at address 0 of the other bank, even when the two samples arrive on back-to-back cycles.
- R4: irq_o goes high in the cycle after the edge that stores the last sample of a bank, and at no other time; with DEPTH-1 samples of a bank stored it is still low.
- R5: ready_bank_o (0 = bank 0, 1 = bank 1) names the bank most recently completed, updated together with the rise of irq_o.
- R6: rd_data_o, one cycle after an edge, holds the byte of the bank named by ready_bank_o at that edge, at the address rd_addr_i held at that edge.
- R7: A cycle with release_i high and no bank completing clears irq_o at the next edge; release_i with no interrupt pending changes nothing.
- R8: When a bank completes while irq_o is high and release_i is low, overrun_o is set, ready_bank_o moves to the new bank and the reads return the new data.
- R9: When a bank completes in the same cycle that release_i is high, irq_o stays high and overrun_o is not set.
- R10: Once set, overrun_o stays high until reset, whatever release_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe for the write side |
| smp_data_i | input | 8 | Sample value |
| rd_addr_i | input | 9 | Read address within the ready bank |
| rd_data_o | output | 8 | Read data, one cycle after the address |
| release_i | input | 1 | Reader acknowledge; frees the ready bank and drops the interrupt |
| irq_o | output | 1 | A completed bank waits to be released |
| ready_bank_o | output | 1 | Index of the bank holding complete data |
| overrun_o | output | 1 | Sticky: a bank was completed before the previous one was released |

## Verification
The assertions watch, on every cycle, the control side: that the fill address holds on idle cycles and wraps into the other bank after the last address, that the interrupt only rises after a completion, that a release clears it, that the ready marker moves only with a pending interrupt, that overrun has a legal cause and never falls, and the outcome of a release coinciding with a completion. Whether the bytes read back are the ones written, in the right bank and at the right address across a bank swap and after an overwrite, can only be shown by the bench's scenarios, which compare every read with a model of both banks.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
  localparam int unsigned NUM_BANKS = 2;
  typedef logic bank_sel_t;
endpackage

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/pp_wr_seq.sv
module pp_wr_seq
  import pp_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output bank_sel_t         wr_bank_o,
  output logic              fill_done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  assign fill_done_o = valid_i && (wr_addr_o == LAST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_o <= '0;
      wr_bank_o <= 1'b0;
    end else if (fill_done_o) begin
      wr_addr_o <= '0;
      wr_bank_o <= ~wr_bank_o;
    end else if (valid_i) begin
      wr_addr_o <= wr_addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/pp_bank_ctl.sv
module pp_bank_ctl
  import pp_buf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fill_done_i,
  input  bank_sel_t done_bank_i,
  input  logic      release_i,
  output logic      irq_o,
  output bank_sel_t ready_bank_o,
  output logic      overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o        <= 1'b0;
      ready_bank_o <= 1'b0;
      overrun_o    <= 1'b0;
    end else if (fill_done_i) begin
      // a same-cycle release frees the older bank, so no overrun
      if (irq_o && !release_i) overrun_o <= 1'b1;
      irq_o        <= 1'b1;
      ready_bank_o <= done_bank_i;
    end else if (release_i) begin
      irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pingpong_sample_buf.sv
module pingpong_sample_buf
  import pp_buf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              release_i,
  output logic              irq_o,
  output logic              ready_bank_o,
  output logic              overrun_o
);
  logic [ADDR_W-1:0] wr_addr;
  bank_sel_t         wr_bank;
  logic              fill_done;
  bank_sel_t         ready_bank;
  bank_sel_t         rd_sel_q;
  logic [DATA_W-1:0] rd_word [NUM_BANKS];

  pp_wr_seq #(.DEPTH(DEPTH)) u_wr_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (smp_valid_i),
    .wr_addr_o   (wr_addr),
    .wr_bank_o   (wr_bank),
    .fill_done_o (fill_done)
  );

  pp_bank_ctl u_bank_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_done_i  (fill_done),
    .done_bank_i  (wr_bank),
    .release_i    (release_i),
    .irq_o        (irq_o),
    .ready_bank_o (ready_bank),
    .overrun_o    (overrun_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pp_bank_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk_i   (clk_i),
      .we_i    (smp_valid_i && (wr_bank == bank_sel_t'(b))),
      .waddr_i (wr_addr),
      .wdata_i (smp_data_i),
      .raddr_i (rd_addr_i),
      .rdata_o (rd_word[b])
    );
  end

  // bank chosen at the address edge steers the registered word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_sel_q <= 1'b0;
    else         rd_sel_q <= ready_bank;
  end

  assign rd_data_o    = rd_word[rd_sel_q];
  assign ready_bank_o = ready_bank;
endmodule

// File: rtl/pingpong_sample_buf_chk.sv
module pingpong_sample_buf_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              release_i,
  input logic              irq_o,
  input logic              ready_bank_o,
  input logic              overrun_o,
  input logic              fill_done,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_bank
);
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(wr_addr) && $stable(wr_bank)); // R2

  AST_BANK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> (wr_addr == '0) && (wr_bank != $past(wr_bank))); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fill_done)); // R4

  AST_READY_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ready_bank_o) |-> irq_o); // R5

  AST_RELEASE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i && !fill_done |=> !irq_o); // R7

  AST_OVERRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(irq_o) && !$past(release_i)); // R8

  AST_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done && release_i |=> irq_o && $stable(overrun_o)); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R10
endmodule

bind pingpong_sample_buf pingpong_sample_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_valid_i  (smp_valid_i),
  .release_i    (release_i),
  .irq_o        (irq_o),
  .ready_bank_o (ready_bank_o),
  .overrun_o    (overrun_o),
  .fill_done    (fill_done),
  .wr_addr      (wr_addr),
  .wr_bank      (wr_bank)
);

// File: tb/pingpong_sample_buf_tb.sv
module pingpong_sample_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 512;
  localparam int ADDR_W     = 9;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              smp_valid_i = 1'b0;
  logic [7:0]        smp_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [7:0]        rd_data_o;
  logic              release_i = 1'b0;
  logic              irq_o, ready_bank_o, overrun_o;

  pingpong_sample_buf u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .release_i(release_i),
    .irq_o(irq_o), .ready_bank_o(ready_bank_o), .overrun_o(overrun_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_mem [2][DEPTH];
  int  m_bank = 0, m_addr = 0, m_ready = 0;
  bit  m_irq = 0, m_ovr = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit fill_event(bit v);
    return v && (m_addr == DEPTH-1);
  endfunction

  // drive one cycle; update model after the edge; return at negedge
  task automatic step(bit v, logic [7:0] d, bit rel);
    bit fill;
    smp_valid_i = v; smp_data_i = d; release_i = rel;
    @(posedge clk_i);
    fill = fill_event(v);
    if (v) exp_mem[m_bank][m_addr] = d;
    if (fill) begin
      if (m_irq && !rel) m_ovr = 1;
      m_irq = 1; m_ready = m_bank; m_bank ^= 1; m_addr = 0;
    end else begin
      if (v) m_addr++;
      if (rel) m_irq = 0;
    end
    @(negedge clk_i);
    smp_valid_i = 0; release_i = 0; smp_data_i = 8'($urandom);
  endtask

  task automatic check_state(string req);
    check({req, " irq"},   32'(irq_o),        32'(m_irq));
    check({req, " ready"}, 32'(ready_bank_o), 32'(m_ready));
    check({req, " ovr"},   32'(overrun_o),    32'(m_ovr));
  endtask

  task automatic rd_check(string req, int a);
    rd_addr_i = ADDR_W'(a);
    step(0, 8'h00, 0);
    check(req, 32'(rd_data_o), 32'(exp_mem[m_ready][a]));
  endtask

  // n samples; gaps randomly inserted when gappy; reads of ready bank run alongside
  task automatic feed(int n, bit gappy, bit rd_along);
    int k = 0;
    while (k < n) begin
      if (gappy && ($urandom % 4 == 0)) begin
        step(0, 8'($urandom), 0);           // R2: idle cycle with junk data
      end else begin
        int a = $urandom % DEPTH;
        logic [7:0] e = exp_mem[m_ready][a];
        rd_addr_i = ADDR_W'(a);
        step(1, 8'($urandom), 0);
        if (rd_along) check("R6 concurrent read", 32'(rd_data_o), 32'(e));
        k++;
      end
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) exp_mem[b][a] = '0;
    repeat (3) @(negedge clk_i);
    check_state("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_state("R1 after release of reset");

    // first sample lands at bank 0 address 0 (R1), gaps ignored (R2)
    feed(DEPTH-1, 1, 0);
    check("R4 no irq before full", 32'(irq_o), 32'd0);
    step(1, 8'hA5, 0);
    check("R4 irq after full", 32'(irq_o), 32'd1);
    check("R5 ready bank 0", 32'(ready_bank_o), 32'd0);
    rd_check("R1 first sample at addr 0", 0);
    rd_check("R6 last addr", DEPTH-1);
    for (int i = 0; i < 20; i++) rd_check("R2 stored data", $urandom % DEPTH);

    step(0, 8'h00, 1);
    check_state("R7 release clears irq");
    step(0, 8'h00, 1);
    check_state("R7 release when idle no effect");

    // back-to-back across the swap: bank 1 then 511 into bank 0 (R3)
    feed(2*DEPTH-1, 0, 1);
    check_state("R5 bank 1 ready");
    rd_check("R3 bank 1 addr 0", 0);
    rd_check("R3 bank 1 last addr", DEPTH-1);
    for (int i = 0; i < 10; i++) rd_check("R3 bank 1 data", $urandom % DEPTH);

    // completion and release on the same edge (R9)
    step(1, 8'h3C, 1);
    check("R9 irq held", 32'(irq_o), 32'd1);
    check("R9 no overrun", 32'(overrun_o), 32'd0);
    check("R5 ready bank 0 again", 32'(ready_bank_o), 32'd0);
    rd_check("R3 bank 0 first of new pass", 0);
    rd_check("R9 last sample", DEPTH-1);

    // writer outruns reader (R8)
    feed(DEPTH, 1, 1);
    check("R8 overrun set", 32'(overrun_o), 32'd1);
    check("R8 ready moved to bank 1", 32'(ready_bank_o), 32'd1);
    check_state("R8 state");
    for (int i = 0; i < 10; i++) rd_check("R8 overwritten data", $urandom % DEPTH);

    step(0, 8'h00, 1);
    check("R10 overrun sticky after release", 32'(overrun_o), 32'd1);
    check("R7 irq cleared", 32'(irq_o), 32'd0);
    feed(DEPTH, 1, 1);
    step(0, 8'h00, 1);
    check_state("R10 sticky after clean pass");

    rst_ni = 1'b0;
    m_bank = 0; m_addr = 0; m_ready = 0; m_irq = 0; m_ovr = 0;
    @(negedge clk_i);
    check_state("R1 reset clears overrun");
    rst_ni = 1'b1;
    @(negedge clk_i);
    report();
  end
endmodule